// File: doc/BRIEF.md
# Switching Cycle Clock Source Selector

This block produces the cycle-start strobes for a two-channel switching regulator controller. Out of reset it times cycles from an internal counter whose period, in system clocks, comes from a programmed period word. Channel B's strobe lands half a period after channel A's, so the two channels run in antiphase.

When the already-thresholded external sync input is first sampled high, the block moves to external mode. There, channel A starts on each qualifying falling edge of the external clock. Channel B follows after half of the most recently measured external period. If qualifying edges stop arriving, the block leaves external mode. It then runs a fixed number of cycles at a slow fixed rate before the programmed period takes over again.

Top module: `swclk_select`

## Requirements
- R1: After synchronous reset, `start_a_o`, `start_b_o` and `sync_mode_o` are all 0, and the block is in internal mode.
- R2: In internal mode, a one-clock pulse on `start_a_o` repeats every P clocks, where P is the clamped period word. The first pulse appears one clock after reset is released.
- R3: The period word is clamped to the range MAX_PERIOD/8 to MAX_PERIOD (8 to 64 with defaults), so values of 0..7 act as 8 and values above 64 act as 64.
- R4: In internal mode, `start_b_o` pulses P>>1 clocks after each `start_a_o` pulse.
- R5: When `sync_i` is sampled high at a clock edge while not in external mode, `sync_mode_o` is 1 from that edge on.
- R6: In external mode, a falling edge is a sample of 0 on `sync_i` directly after a sample of 1. A qualifying falling edge makes `start_a_o` pulse for the clock that follows that edge. The first falling edge after entering external mode only sets the timing reference and produces no strobe.
- R7: A falling edge qualifies only if both conditions hold. First, its fall-to-fall interval T (in clocks) lies within the clamp range of R3. Second, its high time H (the clocks from the last rising edge to this fall) satisfies T <= 5H <= 4T. A falling edge that fails either condition produces no strobe and does not restart the loss timer.
- R8: In external mode, `start_b_o` pulses T>>1 clocks after each `start_a_o`, where T is the interval of the qualifying edge. A pending channel-B strobe is dropped if the block leaves external mode.
- R9: If 2*MAX_PERIOD clocks pass after entering external mode, or after the last qualifying edge, without a new qualifying edge, `sync_mode_o` drops and the block enters fallback.
- R10: Fallback runs FB_CYCLES (16) cycles with a period of 2*MAX_PERIOD clocks, with channel B at half that period. The first fallback strobe comes one clock after fallback is entered. After the last fallback cycle, the programmed period resumes.
- R11: A high sample on `sync_i` during fallback re-enters external mode at once, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Programmed cycle period in system clocks |
| sync_i | input | 1 | Thresholded external sync level |
| start_a_o | output | 1 | Channel A cycle-start pulse |
| start_b_o | output | 1 | Channel B cycle-start pulse |
| sync_mode_o | output | 1 | 1 while locked to the external clock |

## Verification
Each fault class shows up at the ports within a bounded time:
- A corrupted oscillator count moves the next `start_a_o` or `start_b_o` pulse within one period.
- A wrong edge measurement shifts channel B, or makes a strobe appear or vanish, on the very next external falling edge.
- A faulty loss timer or fallback counter changes the moment `sync_mode_o` falls, or the moment the slow period gives way. That shows within one timeout window, or within 16 slow cycles.

Every clock, a behavioural model that tracks edge times is compared with all three outputs. The run covers clamped periods, duty and range rejects, clock loss and re-entry during fallback.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'd0,
        SRC_EXTERNAL = 2'd1,
        SRC_FALLBACK = 2'd2
    } src_mode_e;

    typedef struct packed {
        logic fire_a;
        logic fire_b;
        logic wrap;
    } osc_evt_t;

    function automatic int clamp_period(input int p, input int lo, input int hi);
        if (p < lo) return lo;
        if (p > hi) return hi;
        return p;
    endfunction

    function automatic logic duty_in_band(input int high_len, input int per);
        return (5 * high_len >= per) && (5 * high_len <= 4 * per);
    endfunction

endpackage

// File: rtl/swclk_meter.sv
module swclk_meter
    import swclk_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int MIN_P = 8,
    parameter int MAX_P = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             clear,
    output logic             qual,
    output logic [CNT_W-1:0] meas_per
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             sync_r;
    logic [CNT_W-1:0] since_fall;
    logic [CNT_W-1:0] high_len;
    logic             have_prev;
    logic             rise, fall, per_ok, duty_ok;

    assign rise    = sync_i & ~sync_r;
    assign fall    = ~sync_i & sync_r;
    assign per_ok  = (int'(since_fall) >= MIN_P) && (int'(since_fall) <= MAX_P);
    assign duty_ok = duty_in_band(int'(high_len), int'(since_fall));
    assign qual    = fall & have_prev & ~clear & per_ok & duty_ok;
    assign meas_per = since_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_r     <= 1'b0;
            since_fall <= SAT;
            high_len   <= '0;
            have_prev  <= 1'b0;
        end else begin
            sync_r     <= sync_i;
            since_fall <= fall ? ONE : ((since_fall == SAT) ? SAT : since_fall + ONE);
            high_len   <= rise ? ONE : ((high_len == SAT) ? SAT : high_len + ONE);
            have_prev  <= clear ? 1'b0 : (fall ? 1'b1 : have_prev);
        end
    end

    // R6
    ref_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(have_prev) |-> ($past(sync_r) && !$past(sync_i)));

    // R7
    qual_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        qual |-> (meas_per <= CNT_W'(MAX_P)));

endmodule

// File: rtl/swclk_osc.sv
module swclk_osc
    import swclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] cur_per,
    output osc_evt_t         evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] half_idx;

    assign last_idx   = cur_per - ONE;
    assign half_idx   = cur_per >> 1;
    assign evt.fire_a = run && (cnt == '0);
    assign evt.fire_b = run && (cnt == half_idx);
    assign evt.wrap   = run && (cnt >= last_idx);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt >= last_idx) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R4
    split_phase_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fire_a |-> !evt.fire_b);

    // R2
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/swclk_mode.sv
module swclk_mode
    import swclk_pkg::*;
#(
    parameter int TIMEOUT   = 128,
    parameter int FB_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_i,
    input  logic      qual,
    input  logic      wrap,
    output src_mode_e mode
);
    localparam int IDLE_W = $clog2(TIMEOUT + 1);
    localparam int FB_W   = $clog2(FB_CYCLES + 1);

    logic [IDLE_W-1:0] idle;
    logic [FB_W-1:0]   fb_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= SRC_INTERNAL;
            idle   <= '0;
            fb_cnt <= '0;
        end else begin
            unique case (mode)
                SRC_EXTERNAL: begin
                    if (qual) begin
                        idle <= '0;
                    end else if (idle == IDLE_W'(TIMEOUT - 1)) begin
                        mode   <= SRC_FALLBACK;
                        fb_cnt <= '0;
                        idle   <= '0;
                    end else begin
                        idle <= idle + IDLE_W'(1);
                    end
                end
                SRC_FALLBACK: begin
                    if (sync_i) begin
                        mode <= SRC_EXTERNAL;
                        idle <= '0;
                    end else if (wrap) begin
                        if (fb_cnt == FB_W'(FB_CYCLES - 1)) begin
                            mode   <= SRC_INTERNAL;
                            fb_cnt <= '0;
                        end else begin
                            fb_cnt <= fb_cnt + FB_W'(1);
                        end
                    end
                end
                default: begin
                    if (sync_i) begin
                        mode <= SRC_EXTERNAL;
                        idle <= '0;
                    end
                end
            endcase
        end
    end

    // R10
    fb_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fb_cnt) < FB_CYCLES);

    // R9
    idle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(idle) < TIMEOUT);

    // R9
    exit_to_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == SRC_EXTERNAL && mode != SRC_EXTERNAL) |-> (mode == SRC_FALLBACK));

endmodule

// File: rtl/swclk_select.sv
module swclk_select
    import swclk_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MAX_PERIOD = 64,
    parameter int FB_CYCLES  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic             sync_i,
    output logic             start_a_o,
    output logic             start_b_o,
    output logic             sync_mode_o
);
    localparam int MIN_PERIOD = MAX_PERIOD / 8;
    localparam int FB_PERIOD  = 2 * MAX_PERIOD;
    localparam int TIMEOUT    = 2 * MAX_PERIOD;

    src_mode_e        mode;
    osc_evt_t         osc_evt;
    logic             qual;
    logic [CNT_W-1:0] meas_per;
    logic [CNT_W-1:0] cur_per;
    logic [CNT_W-1:0] b_cnt;
    logic             in_ext;
    logic             ext_fire_b;

    assign in_ext     = (mode == SRC_EXTERNAL);
    assign ext_fire_b = in_ext && (b_cnt == CNT_W'(1));
    assign cur_per    = (mode == SRC_FALLBACK) ? CNT_W'(FB_PERIOD)
                      : CNT_W'(clamp_period(int'(period_i), MIN_PERIOD, MAX_PERIOD));
    assign sync_mode_o = in_ext;

    swclk_meter #(.CNT_W(CNT_W), .MIN_P(MIN_PERIOD), .MAX_P(MAX_PERIOD)) u_meter (
        .clk(clk), .rst(rst), .sync_i(sync_i), .clear(!in_ext),
        .qual(qual), .meas_per(meas_per)
    );

    swclk_osc #(.CNT_W(CNT_W)) u_osc (
        .clk(clk), .rst(rst), .run(!in_ext), .cur_per(cur_per), .evt(osc_evt)
    );

    swclk_mode #(.TIMEOUT(TIMEOUT), .FB_CYCLES(FB_CYCLES)) u_mode (
        .clk(clk), .rst(rst), .sync_i(sync_i), .qual(qual),
        .wrap(osc_evt.wrap), .mode(mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            b_cnt     <= '0;
            start_a_o <= 1'b0;
            start_b_o <= 1'b0;
        end else begin
            if (!in_ext)               b_cnt <= '0;
            else if (qual)             b_cnt <= meas_per >> 1;
            else if (b_cnt != '0)      b_cnt <= b_cnt - CNT_W'(1);
            start_a_o <= in_ext ? qual : osc_evt.fire_a;
            start_b_o <= in_ext ? ext_fire_b : osc_evt.fire_b;
        end
    end

    // R5
    entry_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_mode_o) |-> $past(sync_i));

    // R6
    start_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (start_a_o && $past(sync_mode_o)) |-> !$past(sync_i));

    // R8
    half_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(b_cnt) <= MAX_PERIOD / 2);

endmodule

// File: tb/swclk_select_bench.sv
module swclk_select_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MINP = 8;
    localparam int MAXP = 64;
    localparam int FBP  = 128;
    localparam int TMO  = 128;
    localparam int FBN  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] period_i = 8'd20;
    logic       sync_i = 1'b0;
    logic       start_a_o, start_b_o, sync_mode_o;

    swclk_select u_swclk_select (
        .clk(clk), .rst(rst), .period_i(period_i), .sync_i(sync_i),
        .start_a_o(start_a_o), .start_b_o(start_b_o), .sync_mode_o(sync_mode_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;
    bit armed   = 0;
    string tag_a = "R1", tag_b = "R1", tag_m = "R1";

    // reference model state
    int mst = 0, n = 0, t_fall = -1, t_rise = 0, t_good = 0, pend_b = -1, phase = 0, fbw = 0;
    bit prev_s = 0;
    bit ea = 0, eb = 0, em = 0;

    function automatic int clampv(int p);
        if (p < MINP) return MINP;
        if (p > MAXP) return MAXP;
        return p;
    endfunction

    always @(posedge clk) begin
        int p, h, cp;
        bit s, rise, fall, good, wrap, na, nb;
        cycles++;
        if (rst) begin
            mst = 0; t_fall = -1; pend_b = -1; phase = 0; fbw = 0; prev_s = 0;
            ea = 0; eb = 0; em = 0; armed = 1;
        end else begin
            s = sync_i; rise = s && !prev_s; fall = !s && prev_s;
            na = 0; nb = 0; p = 0;
            if (mst == 1) begin
                good = 0;
                if (fall && t_fall >= 0) begin
                    p = n - t_fall; h = n - t_rise;
                    if (p >= MINP && p <= MAXP && 5 * h >= p && 5 * h <= 4 * p) good = 1;
                end
                na = good; nb = (pend_b == n);
                if (good) begin
                    t_good = n; pend_b = n + p / 2;
                end else if (n - t_good == TMO) begin
                    mst = 2; fbw = 0; phase = 0; pend_b = -1;
                end
                if (fall) t_fall = n;
            end else begin
                cp = (mst == 2) ? FBP : clampv(int'(period_i));
                na = (phase == 0); nb = (phase == cp / 2);
                wrap = (phase >= cp - 1);
                phase = wrap ? 0 : phase + 1;
                t_fall = -1;
                if (s) begin
                    mst = 1; t_good = n; pend_b = -1; phase = 0;
                end else if (mst == 2 && wrap) begin
                    fbw++;
                    if (fbw == FBN) mst = 0;
                end
            end
            if (rise) t_rise = n;
            prev_s = s;
            ea = na; eb = nb; em = (mst == 1);
        end
        n++;
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            vectors++;
            if (start_a_o !== ea) begin
                misses++;
                $display("FAIL %s start_a actual=%b expected=%b at cycle %0d", tag_a, start_a_o, ea, cycles);
            end
            if (start_b_o !== eb) begin
                misses++;
                $display("FAIL %s start_b actual=%b expected=%b at cycle %0d", tag_b, start_b_o, eb, cycles);
            end
            if (sync_mode_o !== em) begin
                misses++;
                $display("FAIL %s sync_mode actual=%b expected=%b at cycle %0d", tag_m, sync_mode_o, em, cycles);
            end
        end
        if (cycles > 150000 && !done) begin
            done = 1; misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    task automatic wait_clks(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic ext_clk(int hi, int per, int count);
        for (int i = 0; i < count; i++) begin
            sync_i = 1'b1; wait_clks(hi);
            sync_i = 1'b0; wait_clks(per - hi);
        end
    endtask

    initial begin
        // R1: reset state
        tag_a = "R1"; tag_b = "R1"; tag_m = "R1";
        wait_clks(4);
        rst = 1'b0;
        // R2 / R4: internal oscillator
        tag_a = "R2"; tag_b = "R4"; tag_m = "R2";
        wait_clks(100);
        period_i = 8'd33; wait_clks(120);
        // R3: clamping
        tag_a = "R3"; tag_b = "R3"; tag_m = "R3";
        period_i = 8'd3;   wait_clks(60);
        period_i = 8'd0;   wait_clks(40);
        period_i = 8'd200; wait_clks(160);
        period_i = 8'd20;  wait_clks(25);
        // R5 / R6 / R8: external lock
        tag_a = "R6"; tag_b = "R8"; tag_m = "R5";
        ext_clk(16, 40, 6);
        ext_clk(30, 60, 3);
        // R7: rejected edges
        tag_a = "R7"; tag_b = "R7"; tag_m = "R7";
        ext_clk(4, 40, 1);
        ext_clk(20, 40, 2);
        ext_clk(36, 40, 1);
        ext_clk(20, 40, 2);
        ext_clk(3, 6, 4);
        ext_clk(20, 40, 2);
        ext_clk(35, 70, 2);
        // R9 / R10: loss and fallback
        tag_a = "R10"; tag_b = "R10"; tag_m = "R9";
        sync_i = 1'b0;
        wait_clks(2400);
        // R11: re-entry during fallback
        tag_a = "R11"; tag_b = "R8"; tag_m = "R11";
        ext_clk(15, 30, 4);
        wait_clks(200);
        ext_clk(25, 50, 4);
        tag_a = "R10"; tag_b = "R10"; tag_m = "R9";
        wait_clks(2300);
        tag_a = "R2"; tag_b = "R4"; tag_m = "R2";
        period_i = 8'd11; wait_clks(80);
        done = 1;
        report();
    end
endmodule